// File: doc/BRIEF.md
# Decoded-Control Integer ALU

This block is a 32-bit integer arithmetic/logic unit together with the small control decoder that steers it. The main controller supplies a 2-bit instruction-class code; for register-to-register instructions the 6-bit function field of the instruction word then picks the exact operation. The decoder turns these inputs into two internal controls: an invert-B bit and a 2-bit operation select. The datapath produces the AND, OR, sum/difference or set-on-less-than result, along with a zero flag and a signed-overflow flag.

Subtraction reuses the adder. Operand B is inverted and the carry-in is forced to 1, which forms the two's-complement difference. The same difference drives the less-than decision and the zero flag that a branch-on-equal or branch-on-not-equal tests. The unit is purely combinational, so outputs follow inputs within the same cycle. It has no state, and therefore no state machine and no reset.

The adder is built either as a generated chain of one-bit slices or as a single behavioural sum, selected by a parameter.

Top module: `alu_core`

## Requirements
- R1: The internal operation select uses the fixed encoding 2'b00 AND, 2'b01 OR, 2'b10 add, 2'b11 set-on-less-than. With class code 2'b10, these function codes are decoded: 6'h20 add, 6'h22 subtract, 6'h24 AND, 6'h25 OR, 6'h2A set-on-less-than.
- R2: Subtraction inverts B and sets the adder carry-in to 1, giving `result = opa - opb` modulo 2^32. Inversion is applied for subtract, for set-on-less-than and for class code 2'b01.
- R3: For add and subtract, `overflow` is 1 exactly when the true signed result lies outside the 32-bit signed range. For AND, OR and set-on-less-than it is 0.
- R4: The function field is ignored for class codes other than 2'b10. Codes 2'b00 and 2'b11 give add, and code 2'b01 gives subtract.
- R5: Set-on-less-than returns 1 when `opa < opb` as signed numbers and 0 otherwise. The decision takes subtraction overflow into account, and bits 31..1 of the result are always 0.
- R6: `zero` is 1 exactly when every bit of `result` is 0, so under class code 2'b01 it reports whether the operands are equal.
- R7: With class code 2'b10, any function code not listed in R1 performs add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op | input | 2 | Instruction-class code from the main control |
| funct | input | 6 | Function field of a register-format instruction |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
The hardest case to reach is a set-on-less-than whose internal subtraction overflows. There the sign bit of the difference gives the wrong answer and only the overflow correction saves it. Random operands almost never produce this. The vector table therefore places the extreme pair (largest positive against most negative, in both orders) next to ordinary compares. A random phase then biases operands toward 0, the largest positive and the most negative value, so that overflowing add, subtract and compare cases occur many times.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;

    // Operation select, fixed encoding (R1)
    typedef enum logic [1:0] {
        SEL_AND = 2'b00,
        SEL_OR  = 2'b01,
        SEL_ADD = 2'b10,
        SEL_SLT = 2'b11
    } alu_sel_e;

    // Instruction-class code from the main control
    typedef enum logic [1:0] {
        CLS_MEM    = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_RTYPE  = 2'b10,
        CLS_SPARE  = 2'b11
    } alu_cls_e;

    localparam int FUNCT_W = 6;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/alu_ctl_decode.sv
module alu_ctl_decode
    import alu_ctl_pkg::*;
(
    input  logic [1:0]         alu_op,
    input  logic [FUNCT_W-1:0] funct,
    output logic               binvert,
    output alu_sel_e           sel
);

    // Function-field decode, used only for register-format instructions
    logic     fn_inv;
    alu_sel_e fn_sel;

    always_comb begin
        unique case (funct)
            FN_ADD:  begin fn_inv = 1'b0; fn_sel = SEL_ADD; end
            FN_SUB:  begin fn_inv = 1'b1; fn_sel = SEL_ADD; end
            FN_AND:  begin fn_inv = 1'b0; fn_sel = SEL_AND; end
            FN_OR:   begin fn_inv = 1'b0; fn_sel = SEL_OR;  end
            FN_SLT:  begin fn_inv = 1'b1; fn_sel = SEL_SLT; end
            default: begin fn_inv = 1'b0; fn_sel = SEL_ADD; end // R7
        endcase
    end

    // Class decode: memory and spare classes add, branch subtracts (R4)
    always_comb begin
        unique case (alu_cls_e'(alu_op))
            CLS_RTYPE:  begin binvert = fn_inv; sel = fn_sel;  end
            CLS_BRANCH: begin binvert = 1'b1;   sel = SEL_ADD; end
            CLS_MEM:    begin binvert = 1'b0;   sel = SEL_ADD; end
            default:    begin binvert = 1'b0;   sel = SEL_ADD; end
        endcase
    end

    always_comb begin
        if (!$isunknown({alu_op, funct})) begin
            // set-on-less-than always needs the inverted operand (R2)
            p_slt_inverts_r2: assert (sel != SEL_SLT || binvert)
                else $error("slt selected without B inversion");
            // function field ignored outside register class (R4)
            p_nonrtype_fixed_r4: assert (alu_op == CLS_RTYPE || sel == SEL_ADD)
                else $error("non-register class did not select add");
        end
    end

endmodule

// File: rtl/alu_adder_path.sv
module alu_adder_path #(
    parameter int WIDTH  = 32,
    parameter bit RIPPLE = 1'b1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             binvert,
    output logic [WIDTH-1:0] b_eff,
    output logic [WIDTH-1:0] sum,
    output logic             ovf_raw,
    output logic             less
);

    localparam int MSB = WIDTH - 1;

    // Invert B and use binvert as carry-in: two's-complement subtract (R2)
    assign b_eff = binvert ? ~b : b;

    generate
        if (RIPPLE) begin : g_ripple
            logic [WIDTH:0] carry;
            assign carry[0] = binvert;
            for (genvar i = 0; i < WIDTH; i++) begin : g_slice
                assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
                assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
            end
        end else begin : g_flat
            logic [WIDTH-1:0] cin_vec;
            assign cin_vec = {{(WIDTH-1){1'b0}}, binvert};
            assign sum     = a + b_eff + cin_vec;
        end
    endgenerate

    // Overflow: operands share a sign that the sum does not (R3)
    assign ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    // Signed less-than corrected for overflow (R5)
    assign less    = sum[MSB] ^ ovf_raw;

    always_comb begin
        if (!$isunknown({a, b, binvert})) begin
            p_sub_twos_r2: assert (!binvert || sum == a - b)
                else $error("inverted path is not a - b");
            p_add_plain_r2: assert (binvert || sum == a + b)
                else $error("plain path is not a + b");
        end
    end

endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
    import alu_ctl_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_sel_e         sel,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] sum,
    input  logic             ovf_raw,
    input  logic             less,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow
);

    always_comb begin
        unique case (sel)
            SEL_AND: result = a & b;
            SEL_OR:  result = a | b;
            SEL_ADD: result = sum;
            SEL_SLT: result = {{(WIDTH-1){1'b0}}, less};
            default: result = sum;
        endcase
    end

    assign zero     = ~|result;                       // R6
    assign overflow = (sel == SEL_ADD) && ovf_raw;    // R3

    always_comb begin
        if (!$isunknown({sel, a, b, sum, ovf_raw, less})) begin
            p_slt_upper_clear_r5: assert (sel != SEL_SLT || result[WIDTH-1:1] == '0)
                else $error("slt result has upper bits set");
            p_no_overflow_r3: assert (sel == SEL_ADD || !overflow)
                else $error("overflow raised on logic or compare");
        end
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_ctl_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter bit RIPPLE = 1'b1
) (
    input  logic [1:0]         alu_op,
    input  logic [FUNCT_W-1:0] funct,
    input  logic [WIDTH-1:0]   opa,
    input  logic [WIDTH-1:0]   opb,
    output logic [WIDTH-1:0]   result,
    output logic               zero,
    output logic               overflow
);

    logic             binvert;
    alu_sel_e         sel;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic             ovf_raw;
    logic             less;

    alu_ctl_decode u_decode (
        .alu_op  (alu_op),
        .funct   (funct),
        .binvert (binvert),
        .sel     (sel)
    );

    alu_adder_path #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_adder (
        .a       (opa),
        .b       (opb),
        .binvert (binvert),
        .b_eff   (b_eff),
        .sum     (sum),
        .ovf_raw (ovf_raw),
        .less    (less)
    );

    alu_result_mux #(.WIDTH(WIDTH)) u_mux (
        .sel      (sel),
        .a        (opa),
        .b        (opb),
        .sum      (sum),
        .ovf_raw  (ovf_raw),
        .less     (less),
        .result   (result),
        .zero     (zero),
        .overflow (overflow)
    );

    always_comb begin
        if (!$isunknown({alu_op, funct, opa, opb})) begin
            // a zero difference means equal operands (R6)
            p_zero_equal_r6: assert (!(binvert && sel == SEL_ADD && zero) || opa == opb)
                else $error("zero flag on unequal operands");
            // branch class always subtracts (R4)
            p_branch_sub_r4: assert (alu_op != CLS_BRANCH || (binvert && sel == SEL_ADD))
                else $error("branch class not subtracting");
        end
    end

endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  alu_op;
    logic [5:0]  funct;
    logic [31:0] opa, opb;
    logic [31:0] result;
    logic        zero, overflow;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;  // 100 MHz

    alu_core u0 (
        .alu_op   (alu_op),
        .funct    (funct),
        .opa      (opa),
        .opb      (opb),
        .result   (result),
        .zero     (zero),
        .overflow (overflow)
    );

    // {alu_op, funct, opa, opb, result, zero, overflow}
    localparam int NV = 18;
    localparam logic [105:0] VEC [NV] = '{
        {2'b10, 6'h20, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b0, 1'b0}, // R1 add
        {2'b10, 6'h22, 32'h0000_0007, 32'h0000_0005, 32'h0000_0002, 1'b0, 1'b0}, // R2 sub
        {2'b10, 6'h24, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F, 1'b0, 1'b0}, // R1 and
        {2'b10, 6'h25, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFFF0_0FFF, 1'b0, 1'b0}, // R1 or
        {2'b10, 6'h2A, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0}, // R5 -1<1
        {2'b10, 6'h2A, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0}, // R5 1<-1
        {2'b10, 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R5 ovf
        {2'b10, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0}, // R5 ovf
        {2'b10, 6'h20, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1}, // R3
        {2'b10, 6'h20, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1}, // R3
        {2'b10, 6'h22, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R3
        {2'b10, 6'h22, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1}, // R3
        {2'b00, 6'h22, 32'h0000_0100, 32'h0000_0020, 32'h0000_0120, 1'b0, 1'b0}, // R4
        {2'b01, 6'h20, 32'h0000_1234, 32'h0000_1234, 32'h0000_0000, 1'b1, 1'b0}, // R6
        {2'b01, 6'h24, 32'h0000_0005, 32'h0000_0003, 32'h0000_0002, 1'b0, 1'b0}, // R4
        {2'b11, 6'h24, 32'h0000_0003, 32'h0000_0004, 32'h0000_0007, 1'b0, 1'b0}, // R4
        {2'b10, 6'h3F, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 1'b0, 1'b0}, // R7
        {2'b10, 6'h20, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0}  // R6
    };
    localparam int VREQ [NV] = '{1, 2, 1, 1, 5, 5, 5, 5, 3, 3, 3, 3, 4, 6, 4, 4, 7, 6};

    // Reference model written from the requirements
    function automatic void ref_model(input logic [1:0] op, input logic [5:0] f,
                                      input logic [31:0] a, input logic [31:0] b,
                                      output logic [31:0] r, output logic z,
                                      output logic v);
        int     kind;  // 0 add, 1 sub, 2 and, 3 or, 4 slt
        longint s;
        if (op == 2'b10) begin
            case (f)
                6'h20:   kind = 0;
                6'h22:   kind = 1;
                6'h24:   kind = 2;
                6'h25:   kind = 3;
                6'h2A:   kind = 4;
                default: kind = 0;
            endcase
        end else if (op == 2'b01) kind = 1;
        else kind = 0;
        v = 1'b0;
        case (kind)
            0: begin
                r = a + b;
                s = longint'($signed(a)) + longint'($signed(b));
                v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            1: begin
                r = a - b;
                s = longint'($signed(a)) - longint'($signed(b));
                v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            2: r = a & b;
            3: r = a | b;
            default: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
        z = (r == 32'd0);
    endfunction

    task automatic apply_check(input logic [1:0] op, input logic [5:0] f,
                               input logic [31:0] a, input logic [31:0] b,
                               input logic [31:0] er, input logic ez,
                               input logic ev, input int req);
        @(posedge clk);
        alu_op = op; funct = f; opa = a; opb = b;
        @(negedge clk);
        checks++;
        if (result !== er || zero !== ez || overflow !== ev) begin
            errors++;
            $display("FAIL R%0d op=%b f=%h a=%h b=%h: got r=%h z=%b v=%b exp r=%h z=%b v=%b",
                     req, op, f, a, b, result, zero, overflow, er, ez, ev);
        end
    endtask

    function automatic logic [31:0] pick_operand();
        case ($urandom % 6)
            0:       return 32'h0000_0000;
            1:       return 32'h7FFF_FFFF;
            2:       return 32'h8000_0000;
            3:       return 32'hFFFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    function automatic logic [5:0] pick_funct();
        case ($urandom % 7)
            0:       return 6'h20;
            1:       return 6'h22;
            2:       return 6'h24;
            3:       return 6'h25;
            4:       return 6'h2A;
            default: return 6'($urandom);
        endcase
    endfunction

    initial begin
        alu_op = 2'b00; funct = 6'h00; opa = '0; opb = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset-time state: zero operands add to zero (R6)
        apply_check(2'b00, 6'h00, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 6);
        // Vector table: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            apply_check(VEC[i][105:104], VEC[i][103:98], VEC[i][97:66], VEC[i][65:34],
                        VEC[i][33:2], VEC[i][1], VEC[i][0], VREQ[i]);
        end
        // Biased random sweep against the reference (R1-covering, R2, R3, R5)
        for (int n = 0; n < 3000; n++) begin
            logic [1:0]  op;
            logic [5:0]  f;
            logic [31:0] a, b, er;
            logic        ez, ev;
            op = 2'($urandom);
            f  = pick_funct();
            a  = pick_operand();
            b  = pick_operand();
            ref_model(op, f, a, b, er, ez, ev);
            apply_check(op, f, a, b, er, ez, ev, 3);
        end
        // Directed: equal operands under branch class (R6) and funct ignored (R4)
        apply_check(2'b01, 6'h2A, 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b1, 1'b0, 6);
        apply_check(2'b00, 6'h2A, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1, 4);
        // slt equal operands gives 0 (R5)
        apply_check(2'b10, 6'h2A, 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b1, 1'b0, 5);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule